// File: doc/BRIEF.md
# Filtered event counter

This block is one counting slice of the performance monitor for a shared cache cluster. Each clock it may receive one transaction report. A report carries an event code, the index of the core or thread that issued it, a request-type code, a data-source code, an 11-bit source ID and a flag that marks the extended channel. A report adds one to the counter only when four things hold: its event code equals the programmed selection, the counter is enabled, the report is valid, and every attribute filter accepts it.

Five filters are available: a thread bitmap, a request-type match, a data-source match with its own enable, a channel selector and a source-ID compare under a mask. Each filter's reset value accepts everything, so an unprogrammed slice counts every report of the selected code. Software writes the configuration through a small write port with an address and a data word. It reads the count directly from the registered count output. A bit in the control word clears the count.

Top module: `evt_filter_cnt`

## Requirements
- R1: After a synchronous reset, the count is zero, the counter is disabled and every filter register holds its pass-all value: thread bitmap 0, request code 0, data-source enable 0, channel code 0 and source-ID mask 0.
- R2: The count rises by exactly one in the clock edge after a cycle that meets all of these conditions: `ev_valid` is 1, the enable bit is set, `ev_code` equals the event-select register (address 1, bits [7:0]) and every filter passes. In any other cycle the count holds, except when it is cleared.
- R3: The thread bitmap is at address 2, bits [NUM_THR-1:0]. When bit i is set, reports from thread i pass, so 0x03 keeps only threads 0 and 1. A bitmap of zero passes every thread.
- R4: The request-type code is at address 3, bits [2:0], and uses these values: 3'b100 read, 3'b101 write, 3'b110 atomic store. A code of 3'b000 passes every report. Any other code passes only reports whose `ev_req` is equal to it.
- R5: The data-source filter is at address 4, with the code in bits [4:0] and the enable in bit 8. When the enable is set, only reports whose 5-bit `ev_dsrc` equals the code pass. Examples of source codes: 5'b00001 near cache, 5'b01110 local DRAM, 5'b10000 remote-socket DRAM.
- R6: The channel code is at address 5, bits [1:0]. 2'b00 passes both channels. 2'b01 and 2'b11 pass only reports with `ev_ext`=1, and 2'b10 passes only reports with `ev_ext`=0. The channel code is ignored for event codes outside 0x47..0x59.
- R7: The source-ID compare value is at address 6, bits [10:0], and its mask is in bits [26:16]. A source ID is a 6-bit super-cluster field [10:5] followed by a 5-bit cluster field [4:0]. A report passes when its ID matches the compare value on every bit that is set in the mask, so a mask of zero passes every report.
- R8: The control word is at address 0. Bit 0 is the enable. Writing a 1 to bit 1 sets the count to zero at that clock edge, and this clear takes precedence over an increment in the same cycle.
- R9: The count is CNT_W bits wide (48 by default). It wraps from all ones to zero.
- R10: A configuration write takes effect at the clock edge that accepts it. A report in that same cycle is still judged against the configuration in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A report is present this cycle |
| ev_code | input | 8 | Event code of the report |
| ev_thread | input | THR_W | Issuing core/thread index |
| ev_req | input | 3 | Request-type code |
| ev_dsrc | input | 5 | Data-source code |
| ev_sid | input | 11 | Source ID (super-cluster, cluster) |
| ev_ext | input | 1 | 1 = extended channel, 0 = base channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cnt | output | CNT_W | Registered event count |

## Verification
Two situations are the hardest to reach from the ports. The first is a wrap that lands in the same cycle as a clear. The second is a configuration write that changes a filter while a report is still being judged under the old settings. The bench runs the counter with a narrow count width. It then enters a mode that forces a passing report every cycle, so the count crosses all ones many times. Clear writes and random configuration writes are issued during these streams. A behavioural model applies the same-cycle ordering, and the bench compares the count against the model on every clock.

// File: rtl/evt_filter_pkg.sv
package evt_filter_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;
  localparam int CODE_W     = 8;
  localparam int REQ_W      = 3;
  localparam int DSRC_W     = 5;
  localparam int SCL_W      = 6;
  localparam int CL_W       = 5;
  localparam int SID_W      = SCL_W + CL_W;
  localparam int CHAN_W     = 2;
  localparam int SID_MSK_LSB = 16;
  localparam int DSRC_EN_BIT = 8;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  localparam logic [CODE_W-1:0] CHAN_CODE_LO = 8'h47;
  localparam logic [CODE_W-1:0] CHAN_CODE_HI = 8'h59;
  localparam logic [REQ_W-1:0]  REQ_ANY      = 3'b000;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_EVSEL   = 3'd1,
    RA_THRMASK = 3'd2,
    RA_REQ     = 3'd3,
    RA_DSRC    = 3'd4,
    RA_CHAN    = 3'd5,
    RA_SID     = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [CODE_W-1:0] evsel;
    logic [REQ_W-1:0]  req;
    logic              dsrc_en;
    logic [DSRC_W-1:0] dsrc;
    logic [CHAN_W-1:0] chan;
    logic [SID_W-1:0]  sid_cmd;
    logic [SID_W-1:0]  sid_msk;
  } flt_cfg_t;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_filter_pkg::*;
#(
  parameter int NUM_THR = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output flt_cfg_t           cfg,
  output logic [NUM_THR-1:0] thr_mask,
  output logic               en,
  output logic               clr
);
  localparam int TOP_USED = SID_MSK_LSB + SID_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:TOP_USED];

  // clear strobe acts in the cycle of the write
  assign clr = we && (addr == RA_CTRL) && wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      thr_mask <= '0;
      en       <= 1'b0;
    end else if (we) begin
      case (addr)
        RA_CTRL:    en           <= wdata[CTRL_EN_BIT];
        RA_EVSEL:   cfg.evsel    <= wdata[CODE_W-1:0];
        RA_THRMASK: thr_mask     <= wdata[NUM_THR-1:0];
        RA_REQ:     cfg.req      <= wdata[REQ_W-1:0];
        RA_DSRC: begin
          cfg.dsrc    <= wdata[DSRC_W-1:0];
          cfg.dsrc_en <= wdata[DSRC_EN_BIT];
        end
        RA_CHAN:    cfg.chan     <= wdata[CHAN_W-1:0];
        RA_SID: begin
          cfg.sid_cmd <= wdata[SID_W-1:0];
          cfg.sid_msk <= wdata[SID_MSK_LSB +: SID_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_filter_match.sv
module evt_filter_match
  import evt_filter_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int THR_W   = 3
) (
  input  logic               ev_valid,
  input  logic [CODE_W-1:0]  ev_code,
  input  logic [THR_W-1:0]   ev_thread,
  input  logic [REQ_W-1:0]   ev_req,
  input  logic [DSRC_W-1:0]  ev_dsrc,
  input  logic [SID_W-1:0]   ev_sid,
  input  logic               ev_ext,
  input  flt_cfg_t           cfg,
  input  logic [NUM_THR-1:0] thr_mask,
  output logic               hit
);
  logic [NUM_THR-1:0] thr_onehot;
  logic thr_ok, req_ok, ds_ok, ch_ok, sid_ok, in_range;

  generate
    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr_dec
      assign thr_onehot[i] = (ev_thread == THR_W'(i));
    end
  endgenerate

  assign thr_ok   = (thr_mask == '0) || (|(thr_onehot & thr_mask));
  assign req_ok   = (cfg.req == REQ_ANY) || (ev_req == cfg.req);
  assign ds_ok    = !cfg.dsrc_en || (ev_dsrc == cfg.dsrc);
  assign in_range = (ev_code >= CHAN_CODE_LO) && (ev_code <= CHAN_CODE_HI);
  assign sid_ok   = ((ev_sid ^ cfg.sid_cmd) & cfg.sid_msk) == '0;

  always_comb begin
    case (cfg.chan)
      2'b00:   ch_ok = 1'b1;
      2'b10:   ch_ok = !ev_ext;
      default: ch_ok = ev_ext;
    endcase
    if (!in_range) ch_ok = 1'b1;
  end

  assign hit = ev_valid && (ev_code == cfg.evsel) &&
               thr_ok && req_ok && ds_ok && ch_ok && sid_ok;
endmodule

// File: rtl/evt_count_accum.sv
module evt_count_accum #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (en && hit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evt_filter_cnt.sv
module evt_filter_cnt
  import evt_filter_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int CNT_W   = 48,
  localparam int THR_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic [CODE_W-1:0]  ev_code,
  input  logic [THR_W-1:0]   ev_thread,
  input  logic [REQ_W-1:0]   ev_req,
  input  logic [DSRC_W-1:0]  ev_dsrc,
  input  logic [SID_W-1:0]   ev_sid,
  input  logic               ev_ext,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [CNT_W-1:0]   cnt
);
  flt_cfg_t           cfg;
  logic [NUM_THR-1:0] thr_mask;
  logic               ctl_en, ctl_clr, hit;

  evt_cfg_regs #(.NUM_THR(NUM_THR)) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(cfg), .thr_mask(thr_mask), .en(ctl_en), .clr(ctl_clr)
  );

  evt_filter_match #(.NUM_THR(NUM_THR), .THR_W(THR_W)) match_i (
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_thread(ev_thread),
    .ev_req(ev_req), .ev_dsrc(ev_dsrc), .ev_sid(ev_sid), .ev_ext(ev_ext),
    .cfg(cfg), .thr_mask(thr_mask), .hit(hit)
  );

  evt_count_accum #(.CNT_W(CNT_W)) accum_i (
    .clk(clk), .rst(rst), .en(ctl_en), .clr(ctl_clr), .hit(hit), .cnt(cnt)
  );
endmodule

// File: rtl/evt_filter_cnt_chk.sv
module evt_filter_cnt_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic             clr_bit,
  input logic             en,
  input logic [CNT_W-1:0] cnt
);
  logic clr_w;
  assign clr_w = cfg_we && (cfg_addr == 3'd0) && clr_bit;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (cnt == '0)); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> (cnt == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid && !clr_w) |=> $stable(cnt)); // R2
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr_w) |=> $stable(cnt)); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr_w |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((&cnt) && !clr_w) |=> ((cnt == '0) || (&cnt))); // R9
endmodule

bind evt_filter_cnt evt_filter_cnt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .clr_bit(cfg_wdata[1]), .en(ctl_en), .cnt(cnt)
);

// File: tb/evt_filter_cnt_tb_top.sv
`timescale 1ns/1ps
module evt_filter_cnt_tb_top;
  localparam int CW = 10;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [7:0] ev_code = '0;
  logic [2:0] ev_thread = '0;
  logic [2:0] ev_req = '0;
  logic [4:0] ev_dsrc = '0;
  logic [10:0] ev_sid = '0;
  logic ev_ext = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [CW-1:0] cnt;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";
  bit all_hit = 0;
  int sel_now = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_en = 0;
  int m_sel = 0, m_thr = 0, m_req = 0, m_ds = 0, m_ch = 0, m_cmd = 0, m_msk = 0;
  bit m_dse = 0;

  always #4 clk = ~clk;

  evt_filter_cnt #(.NUM_THR(NT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_thread(ev_thread), .ev_req(ev_req), .ev_dsrc(ev_dsrc), .ev_sid(ev_sid),
    .ev_ext(ev_ext), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cnt(cnt)
  );

  always @(posedge clk) begin
    bit h, chok;
    int code;
    if (rst) begin
      m_cnt = 0; m_en = 0; m_sel = 0; m_thr = 0; m_req = 0;
      m_dse = 0; m_ds = 0; m_ch = 0; m_cmd = 0; m_msk = 0;
    end else begin
      code = int'(ev_code);
      if (code < 'h47 || code > 'h59 || m_ch == 0) chok = 1;
      else if (m_ch == 2) chok = !ev_ext;
      else chok = ev_ext;
      h = ev_valid && m_en && (code == m_sel)
          && (m_thr == 0 || ((m_thr >> ev_thread) & 1) == 1)
          && (m_req == 0 || int'(ev_req) == m_req)
          && (!m_dse || int'(ev_dsrc) == m_ds)
          && chok
          && (((int'(ev_sid) ^ m_cmd) & m_msk) == 0);
      if (cfg_we && cfg_addr == 0 && cfg_wdata[1]) m_cnt = 0;
      else if (h) m_cnt = (m_cnt + 1) % (1 << CW);
      if (cfg_we) begin
        case (cfg_addr)
          0: m_en = cfg_wdata[0];
          1: m_sel = int'(cfg_wdata[7:0]);
          2: m_thr = int'(cfg_wdata[NT-1:0]);
          3: m_req = int'(cfg_wdata[2:0]);
          4: begin m_ds = int'(cfg_wdata[4:0]); m_dse = cfg_wdata[8]; end
          5: m_ch = int'(cfg_wdata[1:0]);
          6: begin m_cmd = int'(cfg_wdata[10:0]); m_msk = int'(cfg_wdata[26:16]); end
          default: ;
        endcase
      end
    end
  end

  task automatic drive_ev();
    int r;
    ev_valid  = all_hit ? 1'b1 : ($urandom % 5 != 0);
    r = $urandom % 6;
    ev_code   = (all_hit || r != 0) ? 8'(sel_now) : 8'($urandom);
    ev_thread = 3'($urandom);
    r = $urandom % 4;
    ev_req    = (r == 0) ? 3'b100 : (r == 1) ? 3'b101 : (r == 2) ? 3'b110 : 3'($urandom);
    r = $urandom % 4;
    ev_dsrc   = (r == 0) ? 5'b00001 : (r == 1) ? 5'b01110 : (r == 2) ? 5'b10000 : 5'($urandom);
    ev_sid    = {(($urandom % 2) != 0) ? 6'd5 : 6'($urandom), 5'($urandom)};
    ev_ext    = 1'($urandom);
    if (all_hit) begin
      ev_thread = 3'd0; ev_req = 3'b100; ev_dsrc = 5'b01110; ev_sid = {6'd5, 5'd3};
    end
  endtask

  task automatic step();
    @(negedge clk);
    vectors++;
    if (int'(cnt) != m_cnt) begin
      fails++;
      $display("FAIL %s: cnt actual %0d expected %0d at %0t", tag, cnt, m_cnt, $time);
    end
    drive_ev();
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input int a, input int d);
    step();
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    if (a == 1) sel_now = d & 'hff;
  endtask

  task automatic defaults();
    wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0); wr(6, 0);
  endtask

  initial begin
    // R1: reset state and counting disabled after reset
    tag = "R1";
    run(4);
    rst = 1'b0;
    sel_now = 0;
    run(30);
    // R2: plain counting of the selected code
    tag = "R2";
    wr(1, 'h10); wr(0, 1); run(200);
    wr(0, 0); run(40); wr(0, 1);
    // R3: thread bitmap
    tag = "R3";
    wr(2, 'h03); run(200); wr(2, 'h80); run(100); wr(2, 0);
    // R4: request type
    tag = "R4";
    wr(3, 'b100); run(120); wr(3, 'b101); run(120); wr(3, 'b110); run(120); wr(3, 0);
    // R5: data source
    tag = "R5";
    wr(4, 'h100 | 'b01110); run(150); wr(4, 'b00001); run(80);
    wr(4, 'h100 | 'b10000); run(150); wr(4, 0);
    // R6: channel selector, in range then out of range
    tag = "R6";
    wr(1, 'h50);
    wr(5, 1); run(120); wr(5, 3); run(120); wr(5, 2); run(120);
    wr(1, 'h47); run(60); wr(1, 'h59); run(60); wr(1, 'h5a); run(60);
    wr(1, 'h20); run(120); wr(5, 1); run(80); wr(5, 0);
    // R7: masked source-ID compare
    tag = "R7";
    wr(6, ('h7e0 << 16) | (5 << 5)); run(150);
    wr(6, ('h7ff << 16) | (5 << 5) | 3); run(150);
    wr(6, 'h3); run(80); wr(6, 0);
    // R8: clear while counting, including back to back
    tag = "R8";
    all_hit = 1; run(30); wr(0, 3); run(10); wr(0, 3); wr(0, 3); run(20);
    wr(0, 2); run(10); wr(0, 1); all_hit = 0; run(60);
    // R9: wrap of the narrow counter under a passing stream
    tag = "R9";
    defaults(); wr(1, 'h33); all_hit = 1; run(2200); all_hit = 0;
    // R10: configuration changes interleaved with reports
    tag = "R10";
    for (int k = 0; k < 300; k++) begin
      int a;
      a = $urandom % 7;
      case (a)
        0: wr(0, 1 | (($urandom % 8 == 0) ? 2 : 0));
        1: wr(1, (($urandom % 2) != 0) ? 'h4f : 'h10);
        2: wr(2, $urandom % 256);
        3: wr(3, (($urandom % 2) != 0) ? 0 : 4 + ($urandom % 3));
        4: wr(4, (($urandom % 2) != 0) ? 0 : ('h100 | 1));
        5: wr(5, $urandom % 4);
        default: wr(6, (($urandom % 2) != 0) ? 0 : (('h7e0 << 16) | (5 << 5)));
      endcase
      if (k % 20 == 0) all_hit = ~all_hit;
      run(1 + $urandom % 5);
    end
    all_hit = 0;
    run(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule